// File: doc/BRIEF.md
# Debug Module Register Front-End

This block is the register face of a debug module. A debug transport issues word-addressed read and write requests with 32-bit data. The block decodes them into several regions:

- a bank of data words that carry operands to and from abstract commands;
- a bank of program-buffer words;
- a control register that selects a hart and drives halt and resume requests;
- an abstract control/status register with a sticky error field, a busy flag and per-word autoexecute bits;
- a read-only capability register;
- a command register.

Launching an abstract command is handed to a separate sequencer. The launch comes from either a command write or an access to a data word whose autoexecute bit is set. The sequencer ends the command by pulsing `seq_done`, and the harts report their halted state on `hart_halted`.

A two-state machine controls the request port. In **IDLE** the block holds `req_ready` high. The transition **accept** (IDLE to RESP) happens on a cycle where `req_valid` is high, and performs the access. In **RESP** the block presents the registered response for one cycle. The transition **retire** (RESP to IDLE) is taken unconditionally. So a request is accepted at most every second cycle.

Top module: `dbg_regfront`

## Requirements
- R1: `req_ready` is high only in IDLE. A request accepted at a rising edge gets `rsp_valid` high for exactly the following cycle, and `req_ready` is low during that cycle.
- R2: Data words sit at addresses `DATA_BASE` to `DATA_BASE+DCOUNT-1`, and program-buffer words sit at `PB_BASE` to `PB_BASE+PBSIZE-1`. Each word reads back the last value written to it, and both banks reset to zero.
- R3: Any address outside the decoded set returns `rsp_err`=1 and `rsp_rdata`=0, and changes no state.
- R4: A read or write of a data word while busy is set and the error field is 0 (none) sets the error field to 1 (busy).
- R5: An access to data word i whose autoexecute bit i (status bits [16+i]) is set re-launches the last written command. The launch pulses `cmd_launch` with `cmd_word` equal to that command and sets busy.
- R6: A write to the command register stores the value and launches it only when the error field is 0 and busy is clear. If busy is set, the error field becomes 1 instead. Any non-zero error blocks the launch. The command register reads as 0.
- R7: A control write with bit 0 (active) clear resets the whole block state. The control register then reads authenticated (bit 16)=1, version (bits [31:28])=1 and auth type (bits [18:17])=0 (none), with all other control fields 0. The status register reads with busy, error and autoexecute all 0.
- R8: A control write with bit 0 set captures haltreq (bit 1), the reset field (bit 3) and hart select (bits [9:4]). `halt_req` is high only for the selected hart, and only while haltreq is held.
- R9: A control read returns hart status in bits [13:12]: 0 for halted, 1 for running, 2 for a nonexistent hart (select >= `NHARTS`). Bit 1 reads the live halt request of the selected hart, and resume (bit 2) reads 0.
- R10: A write to the status register always loads the autoexecute bits from bits [23:16]. It clears the error field (bits [10:8]) only when the written field is 0.
- R11: The status register reports `DCOUNT` in bits [3:0] and busy in bit 12. The capability register reports `PBSIZE` in bits [4:0].
- R12: A control write with bits 0 and 2 set behaves according to the new hart select. If the selected hart exists, the block pulses `resume_launch` and sets busy. If it does not exist, neither happens.
- R13: A `seq_done` pulse clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Address not decoded |
| hart_halted | input | NHARTS | Halted flag per hart from sequencer |
| seq_done | input | 1 | Sequencer finished, clears busy |
| halt_req | output | NHARTS | Halt request to the selected hart |
| cmd_launch | output | 1 | One-cycle command launch pulse |
| cmd_word | output | 32 | Command being launched |
| resume_launch | output | 1 | One-cycle resume sequence pulse |

## Verification
The embedded assertions check these properties every cycle:
- the one-cycle response and the ready gap;
- that the error field can leave "none" only toward "busy";
- that a command launch always coincides with busy set;
- that busy holds unless the sequencer ends it or the block resets;
- that at most one hart sees a halt request.

Some behaviour shows only in the bench's scenarios, against its reference model:
- the contents of read data and the decoded field positions;
- the conditional clearing of the sticky error;
- autoexecute on a chosen word;
- whether a resume fires, which depends on whether the hart exists.

// File: rtl/dbg_regfront_pkg.sv
package dbg_regfront_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned HSEL_W = 6;
    localparam int unsigned AE_N   = 8;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} fe_state_t;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUSY = 3'd1;

    localparam logic [1:0] HS_HALTED  = 2'd0;
    localparam logic [1:0] HS_RUNNING = 2'd1;
    localparam logic [1:0] HS_ABSENT  = 2'd2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 7'h10;
    localparam logic [ADDR_W-1:0] A_ACS  = 7'h16;
    localparam logic [ADDR_W-1:0] A_CMD  = 7'h17;
    localparam logic [ADDR_W-1:0] A_CAP  = 7'h18;

    // control field positions
    localparam int unsigned CTL_ACTIVE   = 0;
    localparam int unsigned CTL_HALTREQ  = 1;
    localparam int unsigned CTL_RESUME   = 2;
    localparam int unsigned CTL_HRESET   = 3;
    localparam int unsigned CTL_HSEL     = 4;
    localparam int unsigned CTL_HSTAT    = 12;
    localparam int unsigned CTL_AUTHED   = 16;
    localparam int unsigned CTL_AUTHTYPE = 17;
    localparam int unsigned CTL_VERSION  = 28;

    // abstract status field positions
    localparam int unsigned ACS_DCNT   = 0;
    localparam int unsigned ACS_ERR    = 8;
    localparam int unsigned ACS_BUSY   = 12;
    localparam int unsigned ACS_AUTOEX = 16;

    localparam int unsigned CAP_PBSIZE = 0;
endpackage

// File: rtl/dbg_word_bank.sv
module dbg_word_bank #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 32,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                mem[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = mem[i];
    end
endmodule

// File: rtl/dbg_hart_view.sv
module dbg_hart_view
    import dbg_regfront_pkg::*;
#(
    parameter int unsigned NHARTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HSEL_W-1:0] hartsel,
    input  logic              haltreq,
    input  logic [NHARTS-1:0] hart_halted,
    output logic [NHARTS-1:0] halt_req,
    output logic              present,
    output logic              halt_live,
    output logic [1:0]        status
);
    logic sel_halted;

    for (genvar g = 0; g < NHARTS; g++) begin : g_hart
        assign halt_req[g] = haltreq && (hartsel == HSEL_W'(g));
    end

    always_comb begin
        sel_halted = 1'b0;
        for (int i = 0; i < NHARTS; i++)
            if (hartsel == HSEL_W'(i))
                sel_halted = hart_halted[i];
    end

    assign present   = 32'(hartsel) < NHARTS;
    assign halt_live = haltreq && present;
    assign status    = !present ? HS_ABSENT : (sel_halted ? HS_HALTED : HS_RUNNING);

    // R8
    halt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_req));
endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront
    import dbg_regfront_pkg::*;
#(
    parameter int unsigned DATA_BASE = 4,
    parameter int unsigned DCOUNT    = 4,
    parameter int unsigned PB_BASE   = 32,
    parameter int unsigned PBSIZE    = 8,
    parameter int unsigned NHARTS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [6:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NHARTS-1:0] hart_halted,
    input  logic              seq_done,
    output logic [NHARTS-1:0] halt_req,
    output logic              cmd_launch,
    output logic [31:0]       cmd_word,
    output logic              resume_launch
);
    localparam int unsigned DIDX_W = (DCOUNT > 1) ? $clog2(DCOUNT) : 1;
    localparam int unsigned PIDX_W = (PBSIZE > 1) ? $clog2(PBSIZE) : 1;

    fe_state_t state_q, state_d;

    logic [2:0]        err_q, err_d;
    logic              busy_q, busy_d;
    logic [AE_N-1:0]   ae_q, ae_d;
    logic              active_q, active_d;
    logic              hreq_q, hreq_d;
    logic              hrst_q, hrst_d;
    logic [HSEL_W-1:0] hsel_q, hsel_d;
    logic [31:0]       cmd_q, cmd_d;
    logic              launch_q, launch_d;
    logic              resume_q, resume_d;
    logic [31:0]       rdata_q, rdata_d;
    logic              rerr_q, rerr_d;

    logic              accept, d_hit, p_hit, d_we, p_we, present, halt_live, new_present;
    logic [DIDX_W-1:0] d_idx;
    logic [PIDX_W-1:0] p_idx;
    logic [31:0]       d_rd, p_rd;
    logic [1:0]        hstat;
    logic [HSEL_W-1:0] w_hsel;

    assign accept      = req_valid && (state_q == ST_IDLE);
    assign d_hit       = 32'(req_addr) >= DATA_BASE && 32'(req_addr) < DATA_BASE + DCOUNT;
    assign p_hit       = 32'(req_addr) >= PB_BASE && 32'(req_addr) < PB_BASE + PBSIZE;
    assign d_idx       = DIDX_W'(32'(req_addr) - DATA_BASE);
    assign p_idx       = PIDX_W'(32'(req_addr) - PB_BASE);
    assign w_hsel      = req_wdata[CTL_HSEL +: HSEL_W];
    assign new_present = 32'(w_hsel) < NHARTS;

    dbg_word_bank #(.DEPTH(DCOUNT), .W(32)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(d_we), .wr_idx(d_idx),
        .wr_data(req_wdata), .rd_idx(d_idx), .rd_data(d_rd));

    dbg_word_bank #(.DEPTH(PBSIZE), .W(32)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(p_we), .wr_idx(p_idx),
        .wr_data(req_wdata), .rd_idx(p_idx), .rd_data(p_rd));

    dbg_hart_view #(.NHARTS(NHARTS)) u_harts (
        .clk(clk), .rst_n(rst_n), .hartsel(hsel_q), .haltreq(hreq_q),
        .hart_halted(hart_halted), .halt_req(halt_req), .present(present),
        .halt_live(halt_live), .status(hstat));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // access decode and next-state of the register file
    always_comb begin
        err_d = err_q;  busy_d = seq_done ? 1'b0 : busy_q;  ae_d = ae_q;
        active_d = active_q;  hreq_d = hreq_q;  hrst_d = hrst_q;  hsel_d = hsel_q;
        cmd_d = cmd_q;  launch_d = 1'b0;  resume_d = 1'b0;
        rdata_d = '0;  rerr_d = 1'b0;  d_we = 1'b0;  p_we = 1'b0;
        if (accept) begin
            if (d_hit) begin
                d_we = req_write;
                if (!req_write) rdata_d = d_rd;
                if (busy_q && err_q == ERR_NONE) err_d = ERR_BUSY;
                if (32'(d_idx) < AE_N && ae_q[d_idx] && err_q == ERR_NONE) begin
                    if (busy_q) err_d = ERR_BUSY;
                    else begin launch_d = 1'b1; busy_d = 1'b1; end
                end
            end else if (p_hit) begin
                p_we = req_write;
                if (!req_write) rdata_d = p_rd;
            end else begin
                unique case (req_addr)
                    A_CTRL: begin
                        if (req_write && req_wdata[CTL_ACTIVE]) begin
                            active_d = 1'b1;
                            hreq_d   = req_wdata[CTL_HALTREQ];
                            hrst_d   = req_wdata[CTL_HRESET];
                            hsel_d   = w_hsel;
                            if (req_wdata[CTL_RESUME] && new_present) begin
                                resume_d = 1'b1;
                                busy_d   = 1'b1;
                            end
                        end else if (req_write) begin
                            active_d = 1'b0;  hreq_d = 1'b0;  hrst_d = 1'b0;
                            hsel_d = '0;  err_d = ERR_NONE;  busy_d = 1'b0;  ae_d = '0;
                        end else begin
                            rdata_d[CTL_ACTIVE]           = active_q;
                            rdata_d[CTL_HALTREQ]          = halt_live;
                            rdata_d[CTL_HRESET]           = hrst_q;
                            rdata_d[CTL_HSEL +: HSEL_W]   = hsel_q;
                            rdata_d[CTL_HSTAT +: 2]       = hstat;
                            rdata_d[CTL_AUTHED]           = 1'b1;
                            rdata_d[CTL_AUTHTYPE +: 2]    = 2'd0;
                            rdata_d[CTL_VERSION +: 4]     = 4'd1;
                        end
                    end
                    A_ACS: begin
                        if (req_write) begin
                            ae_d = req_wdata[ACS_AUTOEX +: AE_N];
                            if (req_wdata[ACS_ERR +: 3] == ERR_NONE) err_d = ERR_NONE;
                        end else begin
                            rdata_d[ACS_DCNT +: 4]      = 4'(DCOUNT);
                            rdata_d[ACS_ERR +: 3]       = err_q;
                            rdata_d[ACS_BUSY]           = busy_q;
                            rdata_d[ACS_AUTOEX +: AE_N] = ae_q;
                        end
                    end
                    A_CMD: begin
                        if (req_write) begin
                            cmd_d = req_wdata;
                            if (err_q == ERR_NONE) begin
                                if (busy_q) err_d = ERR_BUSY;
                                else begin launch_d = 1'b1; busy_d = 1'b1; end
                            end
                        end
                    end
                    A_CAP: begin
                        if (!req_write) rdata_d[CAP_PBSIZE +: 5] = 5'(PBSIZE);
                    end
                    default: rerr_d = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= ERR_NONE;  busy_q <= 1'b0;  ae_q <= '0;  active_q <= 1'b0;
            hreq_q <= 1'b0;  hrst_q <= 1'b0;  hsel_q <= '0;  cmd_q <= '0;
            launch_q <= 1'b0;  resume_q <= 1'b0;  rdata_q <= '0;  rerr_q <= 1'b0;
        end else begin
            err_q <= err_d;  busy_q <= busy_d;  ae_q <= ae_d;  active_q <= active_d;
            hreq_q <= hreq_d;  hrst_q <= hrst_d;  hsel_q <= hsel_d;  cmd_q <= cmd_d;
            launch_q <= launch_d;  resume_q <= resume_d;  rdata_q <= rdata_d;  rerr_q <= rerr_d;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = (state_q == ST_RESP);
        rsp_rdata     = rdata_q;
        rsp_err       = rerr_q;
        cmd_launch    = launch_q;
        cmd_word      = cmd_q;
        resume_launch = resume_q;
    end

    // R1
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R1
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R4
    err_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == ERR_NONE) |=> (err_q == ERR_NONE || err_q == ERR_BUSY));
    // R6
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_launch |-> busy_q);
    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !seq_done && !(accept && req_write && req_addr == A_CTRL)) |=> busy_q);
endmodule

// File: tb/dbg_regfront_tb.sv
`timescale 1ns/1ps
module dbg_regfront_tb;
    localparam int DBASE = 4, DCNT = 4, PBASE = 32, PBSZ = 8, NH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, seq_done = 1'b0;
    logic [6:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [NH-1:0] hart_halted = '0;
    logic req_ready, rsp_valid, rsp_err, cmd_launch, resume_launch;
    logic [31:0] rsp_rdata, cmd_word;
    logic [NH-1:0] halt_req;

    int n_chk = 0, n_fail = 0, n_launch = 0, n_resume = 0;

    always #2.5 clk = ~clk;

    dbg_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .hart_halted(hart_halted), .seq_done(seq_done), .halt_req(halt_req),
        .cmd_launch(cmd_launch), .cmd_word(cmd_word), .resume_launch(resume_launch));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_idle = 1, m_busy = 0, m_active = 0, m_hreq = 0, m_hrst = 0, started = 0;
    int unsigned m_err = 0, m_ae = 0, m_hsel = 0, m_cmd = 0;
    int unsigned m_data[DCNT];
    int unsigned m_pb[PBSZ];
    bit e_rsp = 0, e_err = 0, e_launch = 0, e_resume = 0;
    int unsigned e_rdata = 0;
    string e_tag = "R1";

    function automatic int unsigned ctrl_view();
        int unsigned v;
        bit pres;
        pres = m_hsel < NH;
        v = m_active | ((m_hreq && pres) << 1) | (m_hrst << 3) | (m_hsel << 4);
        v |= (!pres ? 2 : (hart_halted[m_hsel] ? 0 : 1)) << 12;
        v |= (1 << 16) | (1 << 28);
        return v;
    endfunction

    always @(posedge clk) begin
        bit nb;
        int unsigned a, w;
        e_rsp = 0; e_launch = 0; e_resume = 0;
        if (!rst_n) begin
            m_idle = 1; m_busy = 0; m_active = 0; m_hreq = 0; m_hrst = 0;
            m_err = 0; m_ae = 0; m_hsel = 0; m_cmd = 0;
            foreach (m_data[i]) m_data[i] = 0;
            foreach (m_pb[i]) m_pb[i] = 0;
            started = 1;
        end else begin
            nb = seq_done ? 0 : m_busy;
            if (!m_idle) m_idle = 1;
            else if (req_valid) begin
                m_idle = 0; e_rsp = 1; e_err = 0; e_rdata = 0;
                a = req_addr; w = req_wdata;
                if (a >= DBASE && a < DBASE + DCNT) begin
                    e_tag = "R2";
                    if (req_write) m_data[a-DBASE] = w; else e_rdata = m_data[a-DBASE];
                    if (m_busy && m_err == 0) m_err = 1;
                    if (m_ae[a-DBASE] && m_err == 0) begin
                        if (m_busy) m_err = 1; else begin e_launch = 1; nb = 1; end
                    end
                end else if (a >= PBASE && a < PBASE + PBSZ) begin
                    e_tag = "R2";
                    if (req_write) m_pb[a-PBASE] = w; else e_rdata = m_pb[a-PBASE];
                end else if (a == 'h10) begin
                    e_tag = "R9";
                    if (req_write && w[0]) begin
                        m_active = 1; m_hreq = w[1]; m_hrst = w[3]; m_hsel = (w >> 4) & 'h3f;
                        if (w[2] && m_hsel < NH) begin e_resume = 1; nb = 1; end
                    end else if (req_write) begin
                        m_active = 0; m_hreq = 0; m_hrst = 0; m_hsel = 0;
                        m_err = 0; nb = 0; m_ae = 0;
                    end else e_rdata = ctrl_view();
                end else if (a == 'h16) begin
                    e_tag = "R10";
                    if (req_write) begin
                        m_ae = (w >> 16) & 'hff;
                        if (((w >> 8) & 7) == 0) m_err = 0;
                    end else e_rdata = DCNT | (m_err << 8) | (m_busy << 12) | (m_ae << 16);
                end else if (a == 'h17) begin
                    e_tag = "R6";
                    if (req_write) begin
                        m_cmd = w;
                        if (m_err == 0) begin
                            if (m_busy) m_err = 1; else begin e_launch = 1; nb = 1; end
                        end
                    end
                end else if (a == 'h18) begin
                    e_tag = "R11";
                    if (!req_write) e_rdata = PBSZ;
                end else begin
                    e_tag = "R3"; e_err = 1;
                end
            end
            m_busy = nb;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) if (started) begin
        chk(req_ready == m_idle, "R1 ready", 32'(req_ready), 32'(m_idle));
        chk(rsp_valid == e_rsp, "R1 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
        if (e_rsp) begin
            chk(rsp_rdata == e_rdata, {e_tag, " rdata"}, rsp_rdata, e_rdata);
            chk(rsp_err == e_err, "R3 err", 32'(rsp_err), 32'(e_err));
        end
        chk(cmd_launch == e_launch, "R5/R6 launch", 32'(cmd_launch), 32'(e_launch));
        if (e_launch) chk(cmd_word == m_cmd, "R5 cmd_word", cmd_word, m_cmd);
        chk(resume_launch == e_resume, "R12 resume", 32'(resume_launch), 32'(e_resume));
        chk(32'(halt_req) == ((m_hreq && m_hsel < NH) ? (1 << m_hsel) : 0), "R8 halt_req",
            32'(halt_req), (m_hreq && m_hsel < NH) ? (1 << m_hsel) : 0);
        if (cmd_launch) n_launch++;
        if (resume_launch) n_resume++;
    end

    // ---------------- stimulus ----------------
    task automatic xact(input bit w, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic pulse_done();
        @(negedge clk); seq_done = 1;
        @(negedge clk); seq_done = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic er;
        int l0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        xact(0, 7'h10, 0, rd, er); chk(rd == 32'h1001_1000, "R7 reset ctrl", rd, 32'h1001_1000);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h4, "R11 datacount", rd, 32'h4);
        xact(0, 7'h18, 0, rd, er); chk(rd == 32'h8, "R11 pbsize", rd, 32'h8);
        for (int i = 0; i < DCNT; i++) xact(1, 7'(DBASE + i), 32'hD000_0000 + i, rd, er);
        for (int i = 0; i < PBSZ; i++) xact(1, 7'(PBASE + i), 32'hB000_0000 + i, rd, er);
        xact(0, 7'(DBASE + 2), 0, rd, er); chk(rd == 32'hD000_0002, "R2 data", rd, 32'hD000_0002);
        xact(0, 7'(PBASE + 7), 0, rd, er); chk(rd == 32'hB000_0007, "R2 pbuf", rd, 32'hB000_0007);
        xact(0, 7'h08, 0, rd, er); chk(er == 1 && rd == 0, "R3 undecoded read", {31'b0, er}, 1);
        xact(1, 7'h30, 32'hFFFF_FFFF, rd, er); chk(er == 1, "R3 undecoded write", {31'b0, er}, 1);
        xact(0, 7'(PBASE), 0, rd, er); chk(rd == 32'hB000_0000, "R3 no effect", rd, 32'hB000_0000);
        hart_halted = 4'b0100;
        xact(1, 7'h10, 32'h23, rd, er);
        @(negedge clk); chk(halt_req == 4'b0100, "R8 halt select", 32'(halt_req), 4);
        xact(0, 7'h10, 0, rd, er); chk(rd == 32'h1001_0023, "R9 halted status", rd, 32'h1001_0023);
        l0 = n_launch;
        xact(1, 7'h17, 32'hABCD_0001, rd, er);
        @(negedge clk); chk(n_launch == l0 + 1, "R6 command launch", n_launch, l0 + 1);
        xact(0, 7'h17, 0, rd, er); chk(rd == 0, "R6 cmd reads zero", rd, 0);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h1004, "R11 busy bit", rd, 32'h1004);
        xact(0, 7'(DBASE), 0, rd, er);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h1104, "R4 busy error", rd, 32'h1104);
        l0 = n_launch;
        xact(1, 7'h17, 32'h5555_0000, rd, er);
        @(negedge clk); chk(n_launch == l0, "R6 blocked by error", n_launch, l0);
        xact(1, 7'h16, 32'h0002_0700, rd, er);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h0002_1104, "R10 error kept", rd, 32'h0002_1104);
        xact(1, 7'h16, 32'h0002_0000, rd, er);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h0002_1004, "R10 error cleared", rd, 32'h0002_1004);
        pulse_done();
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h0002_0004, "R13 busy cleared", rd, 32'h0002_0004);
        l0 = n_launch;
        xact(0, 7'(DBASE + 1), 0, rd, er);
        @(negedge clk); chk(n_launch == l0 + 1, "R5 autoexec launch", n_launch, l0 + 1);
        pulse_done();
        l0 = n_resume;
        xact(1, 7'h10, 32'h15, rd, er);
        @(negedge clk); chk(n_resume == l0 + 1, "R12 resume existing", n_resume, l0 + 1);
        pulse_done();
        l0 = n_resume;
        xact(1, 7'h10, 32'h95, rd, er);
        @(negedge clk); chk(n_resume == l0, "R12 no resume absent", n_resume, l0);
        xact(0, 7'h10, 0, rd, er); chk(rd == 32'h1001_2091, "R9 absent hart", rd, 32'h1001_2091);
        xact(1, 7'h17, 32'h1234_5678, rd, er);
        xact(1, 7'h10, 32'h0, rd, er);
        xact(0, 7'h10, 0, rd, er); chk(rd == 32'h1001_1000, "R7 ctrl after reset", rd, 32'h1001_1000);
        xact(0, 7'h16, 0, rd, er); chk(rd == 32'h4, "R7 status after reset", rd, 32'h4);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule